// File: doc/BRIEF.md
# Page-Granular Shared Memory Allocator

This block is the central allocator for a shared address space spread over several separate memory modules. It keeps a table of shared virtual pages, where each valid entry records the owning module and the physical page inside it. Beside it, a per-module table holds the count of pages in use, a bitmap of occupied physical pages and an awake/asleep power bit. Requesters send one request at a time: allocate a byte size, free an allocation by its base address, or look up the physical page behind a virtual page, for example to refill a translation buffer after a miss.

On an allocation the unit rounds the size up to whole 4 KB pages. It picks a module, either the one named in the request or the next one in rotation. It then searches the virtual page slots for a contiguous free run, wakes the module if it is asleep, and writes the pages one per cycle. The answer is either the virtual base address or an all-ones invalid code. Power lines to the modules are driven only here. A module wakes just before pages are placed in it and goes back to sleep when its last page is freed.

Top module: `shmem_page_alloc`

## Requirements
- R1: After reset all modules are asleep (`mod_active` all zero), `req_ready` is high, `resp_valid` is low and every virtual page slot is free.
- R2: An allocate (op 0) rounds `req_size` up to whole 4 KB pages and places them in the lowest-addressed run of that many contiguous free virtual page slots. It returns status 1 with the run's base virtual address (slot index times 4096). A size of zero fails.
- R3: Module identifier 1 lets the unit choose the module. Identifiers 2 to NUM_MODS+1 name module (id minus 2). Any other identifier fails.
- R4: Automatic choice starts at module 0 and steps to the next module, wrapping, after each successful automatic allocation only.
- R5: A sleeping target module is switched awake before any of its pages is placed. An awake module is used without change.
- R6: A failed request returns status 0 and address 0xFFFFFFFF and changes no table, no power state and no rotation pointer. An allocation fails when the target module has fewer free physical pages than requested or no contiguous free virtual run exists.
- R7: A module stays awake while it holds pages and is driven asleep when a free removes its last page. No request can set the power state directly.
- R8: A free (op 1) given the base address of an allocation releases all of that allocation's pages and returns status 1 with the given address. A free of an unallocated page, a non-base page or an address at or beyond 128 pages fails. The page offset bits are ignored.
- R9: A lookup (op 2) of an allocated page returns status 1 and the physical byte address ((module times pages-per-module) plus physical page) times 4096. The physical page is the lowest free one in the module when the page was placed. An unallocated or out-of-range page fails.
- R10: `req_ready` is high only when no request is in flight. Each accepted request yields exactly one single-cycle `resp_valid` pulse before the next is accepted. Op 3 fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted when valid |
| req_op | input | 2 | 0 allocate, 1 free, 2 lookup, 3 reserved |
| req_mod | input | MID_W (4) | Module identifier for allocate |
| req_size | input | SIZE_W (20) | Byte size for allocate |
| req_addr | input | ADDR_W (32) | Virtual address for free and lookup |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_ok | output | 1 | Response status |
| resp_addr | output | ADDR_W (32) | Virtual, physical or echoed address, or all ones |
| mod_active | output | NUM_MODS (4) | Per-module awake line |

## Verification
Lookups, rejected requests and invalid frees respond two cycles after acceptance. An allocation takes a variable time: one cycle per virtual slot scanned, one extra wake cycle for a sleeping module, and one cycle per page placed. A free takes one cycle per page released. For this reason the bench does not predict the response cycle. It samples on falling edges and waits for the single `resp_valid` pulse, up to a bounded number of cycles. It checks `req_ready` one cycle after acceptance, and it checks that the pulse is gone one cycle later. Status, address and the `mod_active` vector are compared at that pulse against a reference model of the tables.

// File: rtl/shmem_alloc_pkg.sv
package shmem_alloc_pkg;

    typedef enum logic [1:0] {
        OP_ALLOC  = 2'd0,
        OP_FREE   = 2'd1,
        OP_LOOKUP = 2'd2,
        OP_RSVD   = 2'd3
    } alloc_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_SCAN,
        ST_WAKE,
        ST_PLACE,
        ST_FREE,
        ST_RESP
    } alloc_st_e;

    // one page table slot: flags plus location
    typedef struct packed {
        logic valid;
        logic head;
        logic last;
    } slot_flags_t;

endpackage

// File: rtl/shmem_page_table.sv
module shmem_page_table
    import shmem_alloc_pkg::*;
#(
    parameter int VPAGES = 128,
    parameter int MOD_W  = 2,
    parameter int PPG_W  = 5,
    localparam int VP_W  = $clog2(VPAGES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VP_W-1:0]  rd_idx,
    output slot_flags_t      rd_flags,
    output logic [MOD_W-1:0] rd_mod,
    output logic [PPG_W-1:0] rd_ppg,
    input  logic             wr_en,
    input  logic [VP_W-1:0]  wr_idx,
    input  slot_flags_t      wr_flags,
    input  logic [MOD_W-1:0] wr_mod,
    input  logic [PPG_W-1:0] wr_ppg
);

    slot_flags_t      flags [VPAGES];
    logic [MOD_W-1:0] owner [VPAGES];
    logic [PPG_W-1:0] ppage [VPAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < VPAGES; i++) flags[i] <= '0;
        end else if (wr_en) begin
            flags[wr_idx] <= wr_flags;
            owner[wr_idx] <= wr_mod;
            ppage[wr_idx] <= wr_ppg;
        end
    end

    assign rd_flags = flags[rd_idx];
    assign rd_mod   = owner[rd_idx];
    assign rd_ppg   = ppage[rd_idx];

    // R2
    no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_flags.valid) |-> !flags[wr_idx].valid);

endmodule

// File: rtl/shmem_module_table.sv
module shmem_module_table #(
    parameter int NUM_MODS = 4,
    parameter int PPM      = 32,
    localparam int MOD_W   = $clog2(NUM_MODS),
    localparam int PPG_W   = $clog2(PPM),
    localparam int CNT_W   = $clog2(PPM + 1)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wake_en,
    input  logic                             place_en,
    input  logic [MOD_W-1:0]                 place_mod,
    output logic [PPG_W-1:0]                 place_ppg,
    input  logic                             rel_en,
    input  logic [MOD_W-1:0]                 rel_mod,
    input  logic [PPG_W-1:0]                 rel_ppg,
    output logic [NUM_MODS-1:0][CNT_W-1:0]   cnt_o,
    output logic [NUM_MODS-1:0]              active_o
);

    logic [NUM_MODS-1:0][PPM-1:0]   used;
    logic [NUM_MODS-1:0][CNT_W-1:0] cnt;
    logic [NUM_MODS-1:0]            active;

    // lowest free physical page of the placement target
    always_comb begin
        logic found;
        found     = 1'b0;
        place_ppg = '0;
        for (int i = 0; i < PPM; i++) begin
            if (!found && !used[place_mod][i]) begin
                place_ppg = PPG_W'(i);
                found     = 1'b1;
            end
        end
    end

    for (genvar m = 0; m < NUM_MODS; m++) begin : g_mod
        logic hit_place, hit_rel;
        assign hit_place = place_en && (place_mod == MOD_W'(m));
        assign hit_rel   = rel_en   && (rel_mod   == MOD_W'(m));

        always_ff @(posedge clk) begin
            if (rst) begin
                used[m]   <= '0;
                cnt[m]    <= '0;
                active[m] <= 1'b0;
            end else begin
                if (wake_en && place_mod == MOD_W'(m)) active[m] <= 1'b1;
                if (hit_place) begin
                    used[m][place_ppg] <= 1'b1;
                    cnt[m]             <= cnt[m] + 1'b1;
                end else if (hit_rel) begin
                    used[m][rel_ppg] <= 1'b0;
                    cnt[m]           <= cnt[m] - 1'b1;
                    if (cnt[m] == CNT_W'(1)) active[m] <= 1'b0;
                end
            end
        end

        // R5
        placed_awake_chk: assert property (@(posedge clk) disable iff (rst)
            hit_place |-> active[m]);
        // R6
        no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
            hit_place |-> (cnt[m] < CNT_W'(PPM)));
        // R8
        no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
            hit_rel |-> (cnt[m] != '0) && used[m][rel_ppg]);
        // R7
        holds_pages_awake_chk: assert property (@(posedge clk) disable iff (rst)
            (cnt[m] != '0) |-> active[m]);
    end

    assign cnt_o    = cnt;
    assign active_o = active;

endmodule

// File: rtl/shmem_page_alloc.sv
module shmem_page_alloc
    import shmem_alloc_pkg::*;
#(
    parameter int NUM_MODS   = 4,
    parameter int SHARED_KB  = 512,
    parameter int PAGE_SHIFT = 12,
    parameter int MID_W      = 4,
    parameter int SIZE_W     = 20,
    parameter int ADDR_W     = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [1:0]          req_op,
    input  logic [MID_W-1:0]    req_mod,
    input  logic [SIZE_W-1:0]   req_size,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic                resp_valid,
    output logic                resp_ok,
    output logic [ADDR_W-1:0]   resp_addr,
    output logic [NUM_MODS-1:0] mod_active
);

    localparam int PAGE_BYTES = 1 << PAGE_SHIFT;
    localparam int VPAGES     = (SHARED_KB * 1024) / PAGE_BYTES;
    localparam int PPM        = VPAGES / NUM_MODS;
    localparam int VP_W       = $clog2(VPAGES);
    localparam int MOD_W      = $clog2(NUM_MODS);
    localparam int PPG_W      = $clog2(PPM);
    localparam int CNT_W      = $clog2(PPM + 1);
    localparam int NP_W       = SIZE_W - PAGE_SHIFT + 1;

    alloc_st_e           st;
    alloc_op_e           op_q;
    logic [MID_W-1:0]    mid_q;
    logic [NP_W-1:0]     np_q, run_q, left_q;
    logic [ADDR_W-1:0]   addr_q, raddr_q;
    logic [VP_W-1:0]     vidx;
    logic [MOD_W-1:0]    tm_q, rr_q;
    logic                auto_q, ok_q, inrange_q;

    slot_flags_t         rd_flags, wr_flags;
    logic [MOD_W-1:0]    rd_mod;
    logic [PPG_W-1:0]    rd_ppg, place_ppg;
    logic                wr_en, place_en, rel_en, wake_en;
    logic [NUM_MODS-1:0][CNT_W-1:0] cnt;
    logic [NUM_MODS-1:0] active;

    // request decode
    logic [SIZE_W:0]     size_up;
    logic                fire;
    assign size_up = {1'b0, req_size} + (SIZE_W+1)'(PAGE_BYTES - 1);
    assign fire    = req_valid && req_ready;

    // allocation target and capacity
    logic                id_auto, id_named, alloc_bad;
    logic [MOD_W-1:0]    tsel;
    logic [NP_W-1:0]     cap;
    assign id_auto  = (mid_q == MID_W'(1));
    assign id_named = (mid_q >= MID_W'(2)) && (mid_q <= MID_W'(NUM_MODS + 1));
    assign tsel     = id_auto ? rr_q : MOD_W'(mid_q - MID_W'(2));
    assign cap      = NP_W'(PPM) - NP_W'(cnt[tsel]);
    assign alloc_bad = !(id_auto || id_named) || (np_q == '0) || (np_q > cap);

    logic [NP_W-1:0]     run_nx;
    logic [VP_W-1:0]     run_base;
    assign run_nx   = run_q + 1'b1;
    assign run_base = vidx - VP_W'(np_q - 1'b1);

    logic [ADDR_W-1:0]   phys_addr;
    assign phys_addr = (ADDR_W'(rd_mod) * ADDR_W'(PPM) + ADDR_W'(rd_ppg)) << PAGE_SHIFT;

    always_comb begin
        wr_en    = 1'b0;
        wr_flags = '0;
        place_en = 1'b0;
        rel_en   = 1'b0;
        wake_en  = (st == ST_WAKE);
        if (st == ST_PLACE) begin
            wr_en          = 1'b1;
            place_en       = 1'b1;
            wr_flags.valid = 1'b1;
            wr_flags.head  = (left_q == np_q);
            wr_flags.last  = (left_q == NP_W'(1));
        end else if (st == ST_FREE) begin
            wr_en  = 1'b1;
            rel_en = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            op_q      <= OP_ALLOC;
            mid_q     <= '0;
            np_q      <= '0;
            run_q     <= '0;
            left_q    <= '0;
            addr_q    <= '0;
            raddr_q   <= '0;
            vidx      <= '0;
            tm_q      <= '0;
            rr_q      <= '0;
            auto_q    <= 1'b0;
            ok_q      <= 1'b0;
            inrange_q <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (fire) begin
                    op_q      <= alloc_op_e'(req_op);
                    mid_q     <= req_mod;
                    np_q      <= NP_W'(size_up >> PAGE_SHIFT);
                    addr_q    <= req_addr;
                    vidx      <= req_addr[PAGE_SHIFT +: VP_W];
                    inrange_q <= (req_addr >> (PAGE_SHIFT + VP_W)) == '0;
                    st        <= ST_CHECK;
                end
                ST_CHECK: begin
                    ok_q    <= 1'b0;
                    raddr_q <= '1;
                    st      <= ST_RESP;
                    case (op_q)
                        OP_ALLOC: if (!alloc_bad) begin
                            tm_q   <= tsel;
                            auto_q <= id_auto;
                            vidx   <= '0;
                            run_q  <= '0;
                            st     <= ST_SCAN;
                        end
                        OP_FREE: if (inrange_q && rd_flags.valid && rd_flags.head) begin
                            st <= ST_FREE;
                        end
                        OP_LOOKUP: if (inrange_q && rd_flags.valid) begin
                            ok_q    <= 1'b1;
                            raddr_q <= phys_addr;
                        end
                        default: ;
                    endcase
                end
                ST_SCAN: begin
                    if (!rd_flags.valid && run_nx == np_q) begin
                        vidx    <= run_base;
                        left_q  <= np_q;
                        raddr_q <= ADDR_W'(run_base) << PAGE_SHIFT;
                        st      <= active[tm_q] ? ST_PLACE : ST_WAKE;
                    end else begin
                        run_q <= rd_flags.valid ? '0 : run_nx;
                        vidx  <= vidx + 1'b1;
                        if (vidx == VP_W'(VPAGES - 1)) st <= ST_RESP;
                    end
                end
                ST_WAKE: st <= ST_PLACE;
                ST_PLACE: begin
                    left_q <= left_q - 1'b1;
                    vidx   <= vidx + 1'b1;
                    if (left_q == NP_W'(1)) begin
                        ok_q <= 1'b1;
                        st   <= ST_RESP;
                        if (auto_q)
                            rr_q <= (rr_q == MOD_W'(NUM_MODS - 1)) ? '0 : rr_q + 1'b1;
                    end
                end
                ST_FREE: begin
                    vidx <= vidx + 1'b1;
                    if (rd_flags.last) begin
                        ok_q    <= 1'b1;
                        raddr_q <= addr_q;
                        st      <= ST_RESP;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    shmem_page_table #(
        .VPAGES (VPAGES),
        .MOD_W  (MOD_W),
        .PPG_W  (PPG_W)
    ) u_ptab (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (vidx),
        .rd_flags (rd_flags),
        .rd_mod   (rd_mod),
        .rd_ppg   (rd_ppg),
        .wr_en    (wr_en),
        .wr_idx   (vidx),
        .wr_flags (wr_flags),
        .wr_mod   (tm_q),
        .wr_ppg   (place_ppg)
    );

    shmem_module_table #(
        .NUM_MODS (NUM_MODS),
        .PPM      (PPM)
    ) u_mtab (
        .clk       (clk),
        .rst       (rst),
        .wake_en   (wake_en),
        .place_en  (place_en),
        .place_mod (tm_q),
        .place_ppg (place_ppg),
        .rel_en    (rel_en),
        .rel_mod   (rd_mod),
        .rel_ppg   (rd_ppg),
        .cnt_o     (cnt),
        .active_o  (active)
    );

    assign req_ready  = (st == ST_IDLE);
    assign resp_valid = (st == ST_RESP);
    assign resp_ok    = ok_q;
    assign resp_addr  = raddr_q;
    assign mod_active = active;

    // R10
    one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> !req_ready);
    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);
    // R6
    fail_code_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_ok) |-> (resp_addr == '1));
    // R6
    fail_keeps_power_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CHECK && op_q == OP_ALLOC && alloc_bad) |=> $stable(mod_active));

endmodule

// File: tb/sim_shmem_page_alloc.sv
module sim_shmem_page_alloc;

    localparam int NM = 4;
    localparam int VP = 128;
    localparam int PP = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = '0;
    logic [3:0]  req_mod = '0;
    logic [19:0] req_size = '0;
    logic [31:0] req_addr = '0;
    logic        resp_valid, resp_ok;
    logic [31:0] resp_addr;
    logic [3:0]  mod_active;

    always #2.5 clk = ~clk;

    shmem_page_alloc u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_mod(req_mod), .req_size(req_size), .req_addr(req_addr),
        .resp_valid(resp_valid), .resp_ok(resp_ok), .resp_addr(resp_addr),
        .mod_active(mod_active)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference model of the tables
    bit m_valid [VP];
    bit m_head  [VP];
    bit m_last  [VP];
    int m_mod   [VP];
    int m_ppg   [VP];
    bit m_used  [NM][PP];
    int m_cnt   [NM];
    bit m_act   [NM];
    int m_rr;

    task automatic chk(input bit cond, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] model_act();
        logic [3:0] v;
        for (int m = 0; m < NM; m++) v[m] = m_act[m];
        return v;
    endfunction

    task automatic model_alloc(input int mid, input int size, output bit ok, output logic [31:0] ea);
        int np, tm, s;
        bool_found: begin end
        ok = 0; ea = 32'hFFFF_FFFF;
        np = (size + 4095) / 4096;
        if (mid == 1) tm = m_rr;
        else if (mid >= 2 && mid <= NM + 1) tm = mid - 2;
        else return;
        if (np == 0 || np > PP - m_cnt[tm]) return;
        s = -1;
        for (int b = 0; b + np <= VP && s < 0; b++) begin
            bit fr = 1;
            for (int k = 0; k < np; k++) if (m_valid[b + k]) fr = 0;
            if (fr) s = b;
        end
        if (s < 0) return;
        for (int k = 0; k < np; k++) begin
            int p = 0;
            while (m_used[tm][p]) p++;
            m_used[tm][p] = 1;
            m_valid[s + k] = 1;
            m_head[s + k]  = (k == 0);
            m_last[s + k]  = (k == np - 1);
            m_mod[s + k]   = tm;
            m_ppg[s + k]   = p;
        end
        m_cnt[tm] += np;
        m_act[tm] = 1;
        if (mid == 1) m_rr = (m_rr + 1) % NM;
        ok = 1; ea = s * 4096;
    endtask

    task automatic model_free(input logic [31:0] a, output bit ok, output logic [31:0] ea);
        int v;
        bit fin;
        ok = 0; ea = 32'hFFFF_FFFF;
        if (a >= VP * 4096) return;
        v = int'(a >> 12);
        if (!m_valid[v] || !m_head[v]) return;
        fin = 0;
        while (!fin) begin
            fin = m_last[v];
            m_valid[v] = 0;
            m_used[m_mod[v]][m_ppg[v]] = 0;
            m_cnt[m_mod[v]]--;
            if (m_cnt[m_mod[v]] == 0) m_act[m_mod[v]] = 0;
            v++;
        end
        ok = 1; ea = a;
    endtask

    task automatic model_lookup(input logic [31:0] a, output bit ok, output logic [31:0] ea);
        int v;
        ok = 0; ea = 32'hFFFF_FFFF;
        if (a >= VP * 4096) return;
        v = int'(a >> 12);
        if (!m_valid[v]) return;
        ok = 1; ea = (m_mod[v] * PP + m_ppg[v]) * 4096;
    endtask

    // drive one request, wait for its single response pulse
    task automatic run_req(input int op, input int mid, input int size, input logic [31:0] a,
                           output bit ok, output logic [31:0] ra, output bit got);
        int n;
        @(negedge clk);
        req_valid = 1; req_op = op[1:0]; req_mod = mid[3:0];
        req_size = size[19:0]; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        chk(req_ready == 0, "R10", "ready while busy", {31'b0, req_ready}, 32'd0);
        n = 0;
        while (!resp_valid && n < 400) begin
            @(negedge clk);
            n++;
        end
        got = resp_valid;
        ok = resp_ok; ra = resp_addr;
        chk(got, "R10", "response pulse seen", {31'b0, got}, 32'd1);
        @(negedge clk);
        chk(!resp_valid && req_ready, "R10", "pulse ends, idle again",
            {30'b0, resp_valid, req_ready}, 32'd1);
    endtask

    // op with expected values computed by the model
    task automatic do_op(input int op, input int mid, input int size, input logic [31:0] a,
                         input string req);
        bit ok, eok, got;
        logic [31:0] ra, ea;
        case (op)
            0: model_alloc(mid, size, eok, ea);
            1: model_free(a, eok, ea);
            2: model_lookup(a, eok, ea);
            default: begin eok = 0; ea = 32'hFFFF_FFFF; end
        endcase
        run_req(op, mid, size, a, ok, ra, got);
        chk(ok == eok, req, "status", {31'b0, ok}, {31'b0, eok});
        chk(ra == ea, req, "address", ra, ea);
        chk(mod_active == model_act(), req, "power lines", {28'b0, mod_active}, {28'b0, model_act()});
    endtask

    initial begin
        for (int i = 0; i < VP; i++) begin
            m_valid[i] = 0; m_head[i] = 0; m_last[i] = 0; m_mod[i] = 0; m_ppg[i] = 0;
        end
        for (int m = 0; m < NM; m++) begin
            m_cnt[m] = 0; m_act[m] = 0;
            for (int p = 0; p < PP; p++) m_used[m][p] = 0;
        end
        m_rr = 0;
        void'($urandom(32'd2024));

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1, "R1", "ready after reset", {31'b0, req_ready}, 32'd1);
        chk(resp_valid == 0, "R1", "no response after reset", {31'b0, resp_valid}, 32'd0);
        chk(mod_active == 4'b0, "R1", "all asleep", {28'b0, mod_active}, 32'd0);
        do_op(2, 0, 0, 32'h0, "R1");                 // empty table lookup fails

        // R2 R4 R5 automatic placement, rounding up
        do_op(0, 1, 1, 0, "R2");                     // 1 page, module 0 -> 0x0000
        do_op(0, 1, 4097, 0, "R4");                  // 2 pages, module 1 -> 0x1000
        do_op(0, 2, 4096, 0, "R3");                  // named module 0 -> 0x3000
        do_op(2, 0, 0, 32'h1000, "R9");              // module1 page0 -> 0x20000
        do_op(2, 0, 0, 32'h2ABC, "R9");              // offset ignored, module1 page1
        do_op(2, 0, 0, 32'h3000, "R9");              // module0 page1

        // R3 R6 rejected requests
        do_op(0, 0, 4096, 0, "R3");
        do_op(0, 6, 4096, 0, "R3");
        do_op(0, 3, 0, 0, "R2");                     // size zero
        do_op(0, 4, 33 * 4096, 0, "R6");             // exceeds module capacity, module 2 stays asleep
        do_op(3, 0, 0, 0, "R10");                    // reserved op

        // R8 R7 frees
        do_op(1, 0, 0, 32'h2000, "R8");              // non-base page
        do_op(1, 0, 0, 32'h0008_0000, "R8");         // beyond the space
        do_op(1, 0, 0, 32'h1000, "R7");              // module 1 empties, sleeps
        do_op(2, 0, 0, 32'h1000, "R8");              // released page now fails
        do_op(0, 1, 100, 0, "R4");                   // rotation at module 2 -> slot 1

        // R6 fill module 3, then overflow
        do_op(0, 5, 32 * 4096, 0, "R6");
        do_op(0, 5, 4096, 0, "R6");
        do_op(1, 0, 0, 32'h4000, "R7");              // free the 32-page run

        // random mix against the model
        for (int i = 0; i < 400; i++) begin
            int op, mid, sz;
            logic [31:0] a;
            op  = int'($urandom_range(0, 9));
            op  = (op < 4) ? 0 : (op < 7) ? 1 : (op < 9) ? 2 : 3;
            mid = int'($urandom_range(0, 6));
            if (mid == 0 && $urandom_range(0, 1) == 1) mid = 1;
            sz  = int'($urandom_range(0, 5 * 4096));
            a   = ($urandom_range(0, 19) == 0) ? 32'h0009_0000
                                               : {13'b0, 7'($urandom_range(0, VP - 1)), 12'h0};
            do_op(op, mid, sz, a, (op == 0) ? "R2" : (op == 1) ? "R8" : (op == 2) ? "R9" : "R10");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R10 watchdog expired: actual %0d expected %0d", 1, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule